// File: doc/BRIEF.md
# Single-Channel Memory Copy Sequencer

This block copies a run of halfwords or words from one bus address range to another. Software sets it up through four registers: a source address, a destination address, a beat count and a control word. It then performs the copy on a simple request/ready memory bus. Each beat is one read from the source, followed by one write of the same data to the destination. Each address then moves up, moves down or stays where it is, as its control code selects.

A copy starts in one of two ways. It can start at once, when the enable bit goes from 0 to 1 with the start mode set to zero. In any other start mode, setting enable only arms the channel, and a one-cycle trigger pulse then starts the copy. On a channel built as an audio channel, start mode 3 is a refill mode. It ignores the beat count, the unit size and the destination stepping, and moves exactly four words to one fixed destination address. Destination code 3 leaves the channel armed after each burst and reloads the destination address before the next one.

Top module: `dma_seq`

## Requirements
- R1: After reset the control readback `ctrl_q` is 0, `busy` is 0 and `bus_req` is 0.
- R2: A control write that raises enable (`ctrl_q[15]`) while start mode (`ctrl_q[6:5]`) is 0 puts the first read request on the bus in the next cycle, at the source register address.
- R3: With a nonzero start mode, setting enable makes no bus request. A `trig` pulse while enabled and idle starts the copy. A `trig` pulse while disabled is ignored.
- R4: Unit bit `ctrl_q[4]` = 0 moves halfwords (`bus_word` = 0, address step 2). A value of 1 moves words (`bus_word` = 1, step 4).
- R5: Source code `ctrl_q[3:2]` selects the source stepping: 0 increments, 1 decrements, 2 holds the address, and 3 increments.
- R6: Destination code `ctrl_q[1:0]` selects the destination stepping: 0 increments, 1 decrements, 2 holds the address, and 3 increments. Under code 3, the destination restarts from the destination register at every burst.
- R7: A burst issues one read and then one write per beat, for the number of beats in the count register. Each write carries exactly the data returned by the read before it.
- R8: When the last write is accepted, enable clears, unless the destination code is 3. In that case enable stays set and the channel waits for the next trigger.
- R9: On an audio channel (parameter `SOUND_CHAN` nonzero), start mode 3 performs four word beats, all written to the destination register address, whatever the count, unit and destination code. The source steps by 4.
- R10: A beat moves on only when `bus_ready` is high. While a request waits, the address and the direction stay unchanged.
- R11: Control writes are byte-masked. `cfg_be[0]` updates bits 6:0 and `cfg_be[1]` updates bit 15. An unselected lane keeps its old value.
- R12: `busy` is high from the cycle after the start until the last write is accepted.
- R13: A count of zero makes no bus request, and enable clears one cycle after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| cfg_be | input | 2 | Byte lanes for control writes (bit 0 low byte, bit 1 high byte) |
| cfg_wdata | input | AW | Write data |
| trig | input | 1 | Start pulse for triggered modes |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_word | output | 1 | 1 for a word access, 0 for a halfword access |
| bus_addr | output | AW | Byte address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid while `bus_ready` is high |
| bus_ready | input | 1 | Completes the current request |
| busy | output | 1 | Burst in progress |
| ctrl_q | output | 16 | Control register readback |

## Verification
The assertions assume three things about the inputs. First, the memory side completes a request only by raising `bus_ready` with valid `bus_rdata`. Second, software does not rewrite the control word while a burst runs. Third, `trig` is a single-cycle pulse. The stimulus writes registers only while `busy` is low, and drives `trig` for exactly one cycle. Its memory responder returns read data that is a fixed function of the address, and in one scenario it holds `bus_ready` low for two of every three cycles.

// File: rtl/dma_seq.sv
module dma_seq #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 16,
  parameter int SOUND_CHAN = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [1:0]    cfg_be,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          trig,
  output logic          bus_req,
  output logic          bus_we,
  output logic          bus_word,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready,
  output logic          busy,
  output logic [15:0]   ctrl_q
);

  localparam int CW = LW + 1;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} state_t;
  state_t state;

  logic [AW-1:0] src_r, dst_r, cur_src, cur_dst, sstep, dstep;
  logic [LW-1:0] len_r;
  logic [CW-1:0] left;
  logic [DW-1:0] data_r;
  logic [1:0]    c_dst, c_src, c_time;
  logic          c_word, c_en, word_r, keep_r;

  logic          wr_ctrl, n_word, n_en, en_rise, special, eff_word, imm_go, trig_go, go;
  logic [1:0]    n_dst, n_src, n_time;
  logic [CW-1:0] eff_len;
  logic [AW-1:0] unit_step, sstep_n, dstep_n;

  assign wr_ctrl = cfg_we && (cfg_sel == 2'd3);
  assign {n_time, n_word, n_src, n_dst} = (wr_ctrl && cfg_be[0]) ? cfg_wdata[6:0]
                                                                : {c_time, c_word, c_src, c_dst};
  assign n_en    = (wr_ctrl && cfg_be[1]) ? cfg_wdata[15] : c_en;
  assign en_rise = n_en && !c_en;

  assign special  = (SOUND_CHAN != 0) && (n_time == 2'd3);
  assign eff_word = n_word || special;
  assign eff_len  = special ? CW'(4) : {1'b0, len_r};

  assign imm_go  = en_rise && (n_time == 2'd0);
  assign trig_go = trig && c_en && n_en && (n_time != 2'd0);
  assign go      = (state == S_IDLE) && (imm_go || trig_go);

  assign unit_step = eff_word ? AW'(4) : AW'(2);

  always_comb begin
    case (n_src)
      2'd1:    sstep_n = '0 - unit_step;
      2'd2:    sstep_n = '0;
      default: sstep_n = unit_step;
    endcase
    if (special) dstep_n = '0;
    else begin
      case (n_dst)
        2'd1:    dstep_n = '0 - unit_step;
        2'd2:    dstep_n = '0;
        default: dstep_n = unit_step;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      src_r   <= '0;
      dst_r   <= '0;
      len_r   <= '0;
      c_dst   <= '0;
      c_src   <= '0;
      c_time  <= '0;
      c_word  <= 1'b0;
      c_en    <= 1'b0;
      cur_src <= '0;
      cur_dst <= '0;
      sstep   <= '0;
      dstep   <= '0;
      left    <= '0;
      data_r  <= '0;
      word_r  <= 1'b0;
      keep_r  <= 1'b0;
    end else begin
      if (cfg_we && cfg_sel == 2'd0) src_r <= cfg_wdata;
      if (cfg_we && cfg_sel == 2'd1) dst_r <= cfg_wdata;
      if (cfg_we && cfg_sel == 2'd2) len_r <= cfg_wdata[LW-1:0];
      {c_time, c_word, c_src, c_dst} <= {n_time, n_word, n_src, n_dst};
      c_en <= n_en;

      if (en_rise) begin
        cur_src <= src_r;
        cur_dst <= dst_r;
      end

      case (state)
        S_IDLE: begin
          if (go) begin
            if (n_dst == 2'd3) cur_dst <= dst_r;
            if (eff_len == '0) begin
              if (n_dst != 2'd3) c_en <= 1'b0;
            end else begin
              state  <= S_RD;
              left   <= eff_len;
              sstep  <= sstep_n;
              dstep  <= dstep_n;
              word_r <= eff_word;
              keep_r <= (n_dst == 2'd3);
            end
          end
        end
        S_RD: begin
          if (bus_ready) begin
            data_r  <= bus_rdata;
            cur_src <= cur_src + sstep;
            state   <= S_WR;
          end
        end
        S_WR: begin
          if (bus_ready) begin
            cur_dst <= cur_dst + dstep;
            left    <= left - CW'(1);
            if (left == CW'(1)) begin
              state <= S_IDLE;
              if (!keep_r) c_en <= 1'b0;
            end else begin
              state <= S_RD;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign bus_req   = (state != S_IDLE);
  assign bus_we    = (state == S_WR);
  assign bus_addr  = (state == S_WR) ? cur_dst : cur_src;
  assign bus_wdata = data_r;
  assign bus_word  = word_r;
  assign busy      = bus_req;
  assign ctrl_q    = {c_en, 8'b0, c_time, c_word, c_src, c_dst};

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ready |=> bus_req && $stable(bus_addr) && $stable(bus_we));

  // R12
  beats_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> left != '0);

  // R8
  en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !keep_r |-> !c_en);

  // R2
  start_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> c_en);

  // R7
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we && bus_ready |=> bus_req && bus_we);

endmodule

// File: tb/dma_seq_bench.sv
module dma_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [1:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic        trig = 1'b0;
  logic        bus_req, bus_we, bus_word, busy;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic        bus_ready = 1'b1;
  logic [15:0] ctrl_q;

  int errors = 0, checks = 0;
  int nw = 0, nr = 0, hold_err = 0, stall_cnt = 0;
  bit stall_en = 0;
  logic [31:0] w_addr [0:15];
  logic [31:0] w_data [0:15];
  logic        w_word [0:15];
  logic [31:0] r_addr [0:15];
  logic        wait_pend = 0;
  logic [31:0] wait_addr;
  logic        wait_we;

  always #5 clk = ~clk;

  dma_seq u_dma_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .trig(trig), .bus_req(bus_req), .bus_we(bus_we),
    .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .busy(busy), .ctrl_q(ctrl_q)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {16'hC0DE, a[15:0]};
  endfunction

  assign bus_rdata = pat(bus_addr);

  function automatic logic [15:0] ctl(input logic en, input logic [1:0] tim,
                                      input logic word, input logic [1:0] s, input logic [1:0] d);
    return {en, 8'b0, tim, word, s, d};
  endfunction

  always @(negedge clk) begin
    stall_cnt++;
    bus_ready = !stall_en || (stall_cnt % 3 == 0);
    #1;
    if (wait_pend && (!bus_req || bus_addr !== wait_addr || bus_we !== wait_we)) hold_err++;
    wait_pend = 0;
    if (bus_req && bus_ready) begin
      if (bus_we) begin
        if (nw < 16) begin w_addr[nw] = bus_addr; w_data[nw] = bus_wdata; w_word[nw] = bus_word; end
        nw++;
      end else begin
        if (nr < 16) r_addr[nr] = bus_addr;
        nr++;
      end
    end else if (bus_req) begin
      wait_pend = 1; wait_addr = bus_addr; wait_we = bus_we;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d, input logic [1:0] be = 2'b11);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d; cfg_be = be;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pulse;
    @(negedge clk); trig = 1;
    @(negedge clk); trig = 0;
  endtask

  task automatic clear_log;
    #2; nw = 0; nr = 0; hold_err = 0;
  endtask

  task automatic wait_idle;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); #2;
      if (!busy) break;
    end
    @(negedge clk); #2;
  endtask

  task automatic exp_w(input int i, input logic [31:0] a, input logic [31:0] src,
                       input logic word, input string tag);
    chk(w_addr[i] === a, {tag, " write addr"}, w_addr[i], a);
    chk(w_data[i] === pat(src), {tag, " write data"}, w_data[i], pat(src));
    chk(w_word[i] === word, {tag, " unit"}, 32'(w_word[i]), 32'(word));
  endtask

  task automatic exp_r(input int i, input logic [31:0] a, input string tag);
    chk(r_addr[i] === a, {tag, " read addr"}, r_addr[i], a);
  endtask

  task automatic t_reset;
    chk(ctrl_q === 16'h0, "R1 ctrl", 32'(ctrl_q), 0);
    chk(busy === 1'b0, "R1 busy", 32'(busy), 0);
    chk(bus_req === 1'b0, "R1 req", 32'(bus_req), 0);
  endtask

  task automatic t_word_inc;
    clear_log();
    wr(0, 32'h100); wr(1, 32'h200); wr(2, 3);
    wr(3, 32'(ctl(1, 0, 1, 0, 0)));
    #2;
    chk(bus_req === 1 && bus_we === 0 && bus_addr === 32'h100, "R2 first read", bus_addr, 32'h100);
    chk(busy === 1, "R12 busy at start", 32'(busy), 1);
    wait_idle();
    chk(nw == 3 && nr == 3, "R7 beat count", 32'(nw), 3);
    for (int i = 0; i < 3; i++) begin
      exp_r(i, 32'h100 + 32'(4 * i), "R4");
      exp_w(i, 32'h200 + 32'(4 * i), 32'h100 + 32'(4 * i), 1, "R7");
    end
    chk(ctrl_q[15] === 0, "R8 enable cleared", 32'(ctrl_q), 0);
  endtask

  task automatic t_half_dec;
    clear_log();
    wr(0, 32'h140); wr(1, 32'h220); wr(2, 2);
    wr(3, 32'(ctl(1, 0, 0, 1, 2)));
    wait_idle();
    chk(nw == 2, "R7 half count", 32'(nw), 2);
    exp_r(0, 32'h140, "R5 dec"); exp_r(1, 32'h13E, "R5 dec");
    exp_w(0, 32'h220, 32'h140, 0, "R6 fixed");
    exp_w(1, 32'h220, 32'h13E, 0, "R4 half");
  endtask

  task automatic t_src3_dstdec;
    clear_log();
    wr(0, 32'h180); wr(1, 32'h280); wr(2, 2);
    wr(3, 32'(ctl(1, 0, 1, 3, 1)));
    wait_idle();
    exp_r(0, 32'h180, "R5 code3"); exp_r(1, 32'h184, "R5 code3");
    exp_w(0, 32'h280, 32'h180, 1, "R6 dec");
    exp_w(1, 32'h27C, 32'h184, 1, "R6 dec");
  endtask

  task automatic t_trigger;
    clear_log();
    wr(0, 32'h900); wr(1, 32'hA00); wr(2, 1);
    wr(3, 32'(ctl(0, 1, 1, 0, 0)));
    pulse();
    repeat (4) @(negedge clk);
    #2;
    chk(nr == 0 && !busy, "R3 trig while disabled", 32'(nr), 0);
    wr(3, 32'(ctl(1, 1, 1, 0, 0)));
    repeat (5) @(negedge clk);
    #2;
    chk(nr == 0 && ctrl_q[15] === 1, "R3 armed waits", 32'(nr), 0);
    pulse();
    wait_idle();
    chk(nw == 1, "R3 triggered burst", 32'(nw), 1);
    exp_w(0, 32'hA00, 32'h900, 1, "R3");
    chk(ctrl_q[15] === 0, "R8 clear after trigger", 32'(ctrl_q), 0);
  endtask

  task automatic t_reload;
    clear_log();
    wr(0, 32'h400); wr(1, 32'h300); wr(2, 2);
    wr(3, 32'(ctl(1, 2, 1, 0, 3)));
    pulse();
    wait_idle();
    chk(ctrl_q[15] === 1, "R8 stays armed", 32'(ctrl_q), 32'h8000);
    pulse();
    wait_idle();
    chk(nw == 4, "R6 two bursts", 32'(nw), 4);
    exp_w(0, 32'h300, 32'h400, 1, "R6");
    exp_w(1, 32'h304, 32'h404, 1, "R6");
    exp_w(2, 32'h300, 32'h408, 1, "R6 reload");
    exp_w(3, 32'h304, 32'h40C, 1, "R6 reload");
    wr(3, 32'(ctl(0, 0, 0, 0, 0)));
  endtask

  task automatic t_special;
    clear_log();
    wr(0, 32'h500); wr(1, 32'h600); wr(2, 7);
    wr(3, 32'(ctl(1, 3, 0, 0, 0)));
    pulse();
    wait_idle();
    chk(nw == 4, "R9 four beats", 32'(nw), 4);
    for (int i = 0; i < 4; i++) begin
      exp_r(i, 32'h500 + 32'(4 * i), "R9");
      exp_w(i, 32'h600, 32'h500 + 32'(4 * i), 1, "R9");
    end
  endtask

  task automatic t_stall;
    clear_log();
    stall_en = 1;
    wr(0, 32'h700); wr(1, 32'h800); wr(2, 3);
    wr(3, 32'(ctl(1, 0, 1, 0, 0)));
    wait_idle();
    stall_en = 0;
    chk(nw == 3 && nr == 3, "R10 stalled count", 32'(nw), 3);
    for (int i = 0; i < 3; i++) exp_w(i, 32'h800 + 32'(4 * i), 32'h700 + 32'(4 * i), 1, "R10");
    chk(hold_err == 0, "R10 held while waiting", 32'(hold_err), 0);
  endtask

  task automatic t_bytemask;
    clear_log();
    wr(0, 32'hB00); wr(1, 32'hC00); wr(2, 1);
    wr(3, 32'h0000_8005, 2'b01);
    #2;
    chk(ctrl_q === 16'h0005, "R11 low lane only", 32'(ctrl_q), 32'h0005);
    repeat (3) @(negedge clk);
    chk(nr == 0, "R11 no start", 32'(nr), 0);
    wr(3, 32'h0000_80FF, 2'b10);
    #2;
    chk(ctrl_q === 16'h8005, "R11 high lane only", 32'(ctrl_q), 32'h8005);
    wait_idle();
    chk(nw == 1, "R11 start from high lane", 32'(nw), 1);
  endtask

  task automatic t_zero;
    clear_log();
    wr(2, 0);
    wr(3, 32'(ctl(1, 0, 1, 0, 0)));
    #2;
    chk(ctrl_q[15] === 0 && !busy, "R13 zero length", 32'(ctrl_q), 0);
    repeat (3) @(negedge clk);
    chk(nr == 0 && nw == 0, "R13 no bus", 32'(nr + nw), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    t_reset();
    t_word_inc();
    t_half_dec();
    t_src3_dstdec();
    t_trigger();
    t_reload();
    t_special();
    t_stall();
    t_bytemask();
    t_zero();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule